// File: doc/BRIEF.md
# JTAG Shutdown-and-Readback Command Sequencer

This block is a JTAG master. It produces TCK by dividing the system clock, and it drives TMS and TDI so that an attached target TAP runs a fixed configuration script. A single start pulse launches the script. The script resets the TAP and parks it in Run-Test/Idle. It then loads a configuration-input instruction and shifts a list of 16-bit command packets into the data register, followed by two flush words. Next it loads a shutdown instruction, lets the target idle for a set number of TCK cycles, and finally returns the TAP to Test-Logic-Reset.

The packets come from an internal table of up to sixteen entries, and a count input chooses how many of them are sent. Instruction registers are filled least significant bit first. Packets are sent most significant bit first. In every shift, the final bit goes out on the same TCK cycle that leaves the shift state. TMS and TDI only ever change on a falling TCK edge, so the target always samples stable values on the rising edge.

Top module: `jcs_seq`

## Requirements
- R1: The cycle after a start pulse is accepted while idle, `busy` is high. It stays high until the script's final falling TCK edge, and it drops at that edge.
- R2: The script opens with five TCK cycles at TMS=1, followed by one cycle at TMS=0 that leaves the target in Run-Test/Idle.
- R3: Each instruction is `IR_W` (6) bits, shifted LSB first, with TMS=1 on the sixth bit only. The first instruction the target latches is `OPC_CFGIN` (6'h05) and the second is `OPC_SHUTDN` (6'h0D).
- R4: In the single data-register pass, each word is shifted MSB first. The words are table entries 0..n-1 followed by two flush words of 16'h2000. TMS is 1 only on the last bit of the last flush word.
- R5: Table entries 0..4 hold 16'hFFFF, 16'hAA99, 16'h5566, 16'h30A1 and 16'h0007. Entries 5..15 hold 16'h2000. A count above 16 is treated as 16, and a count of 0 sends only the two flush words.
- R6: After the shutdown instruction's Update-IR, TMS stays 0 for `IDLE_TCK` (24) TCK cycles. Five cycles at TMS=1 then follow, which leaves the target in Test-Logic-Reset. The whole script is 61 + 16·(n+2) TCK cycles.
- R7: TMS and TDI never change while TCK is high. They change only in the system cycle in which TCK falls, or at the start of the script while TCK is low.
- R8: TCK has a period of 2·`TCK_HALF` system clocks while busy, and it is held low while idle.
- R9: A start pulse that arrives while busy has no effect: the script in progress is neither restarted nor lengthened.
- R10: When the script ends, `done` is high and `busy` is low. `done` stays high until the next accepted start.
- R11: After reset, `busy`=0, `done`=0, `tck`=0 and `tms`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that launches the script when idle |
| pkt_cnt | input | CNT_W (5) | Number of table packets to send, clamped to ROM_DEPTH |
| tck | output | 1 | Generated test clock |
| tms | output | 1 | Test mode select to the target |
| tdi | output | 1 | Test data to the target |
| busy | output | 1 | High while the script runs |
| done | output | 1 | High from script end until the next start |

## Verification
The hardest situations to reach from the ports are a start pulse that lands partway through a running script, and packet counts at the clamp edge (0, 16, 17 and above). The bench covers the first by firing extra start pulses at random delays while `busy` is high. It then confirms that the total TCK count and the words the target received match a single run. A behavioural target TAP in the bench follows every rising TCK, latches instruction values at Update-IR, and rebuilds the shifted words. This lets the LSB-first and MSB-first orderings, and the exit-on-last-bit rule, be judged from what the target actually saw.

// File: rtl/jcs_pkg.sv
package jcs_pkg;

    // Script phases, in the order they are walked.
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_TLR_IN,
        PH_GO_RTI,
        PH_GO_IR1,
        PH_IR1,
        PH_GO_DR,
        PH_DR,
        PH_GO_IR2,
        PH_IR2,
        PH_GO_UPD,
        PH_WAIT,
        PH_TLR_OUT
    } phase_t;

    typedef struct packed {
        logic tms;
        logic tdi;
    } pin_t;

    localparam int unsigned RESET_TCK = 5;

    // Length of the fixed TMS walks between shifts.
    function automatic int unsigned walk_len(phase_t ph);
        case (ph)
            PH_TLR_IN, PH_TLR_OUT: return RESET_TCK;
            PH_GO_RTI, PH_GO_UPD:  return 1;
            PH_GO_IR1, PH_GO_DR:   return 4;
            PH_GO_IR2:             return 5;
            default:               return 0;
        endcase
    endfunction

    // TMS value of step i of a fixed walk.
    function automatic logic walk_tms(phase_t ph, int unsigned i);
        case (ph)
            PH_TLR_IN, PH_TLR_OUT, PH_GO_UPD: return 1'b1;
            PH_GO_IR1, PH_GO_DR:              return (i < 2);
            PH_GO_IR2:                        return (i < 3);
            default:                          return 1'b0;
        endcase
    endfunction

    function automatic phase_t next_phase(phase_t ph);
        case (ph)
            PH_TLR_IN:  return PH_GO_RTI;
            PH_GO_RTI:  return PH_GO_IR1;
            PH_GO_IR1:  return PH_IR1;
            PH_IR1:     return PH_GO_DR;
            PH_GO_DR:   return PH_DR;
            PH_DR:      return PH_GO_IR2;
            PH_GO_IR2:  return PH_IR2;
            PH_IR2:     return PH_GO_UPD;
            PH_GO_UPD:  return PH_WAIT;
            PH_WAIT:    return PH_TLR_OUT;
            default:    return PH_IDLE;
        endcase
    endfunction

    // Command table: a sync/shutdown header, then no-op words.
    function automatic logic [15:0] rom_word(int unsigned i);
        case (i)
            0:       return 16'hFFFF;
            1:       return 16'hAA99;
            2:       return 16'h5566;
            3:       return 16'h30A1;
            4:       return 16'h0007;
            default: return 16'h2000;
        endcase
    endfunction

endpackage

// File: rtl/jcs_tck_gen.sv
module jcs_tck_gen #(
    parameter int unsigned TCK_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tck,
    output logic fall_p
);
    localparam int unsigned CW = (TCK_HALF > 1) ? $clog2(TCK_HALF) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap   = (cnt == CW'(TCK_HALF - 1));
    assign fall_p = en && tck && wrap;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            tck <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            tck <= ~tck;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // R8
    tck_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !tck);

    generate
        if (TCK_HALF > 1) begin : g_hold
            // R8
            tck_min_half_chk: assert property (@(posedge clk) disable iff (rst)
                (en && $past(en) && $changed(tck)) |=> $stable(tck));
        end
    endgenerate

endmodule

// File: rtl/jcs_pkt_rom.sv
module jcs_pkt_rom #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned PKT_W = 16,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [AW-1:0]    addr,
    output logic [PKT_W-1:0] data
);
    logic [PKT_W-1:0] mem [DEPTH];

    generate
        for (genvar g = 0; g < int'(DEPTH); g++) begin : g_ent
            assign mem[g] = PKT_W'(jcs_pkg::rom_word(g));
        end
    endgenerate

    assign data = mem[addr];

endmodule

// File: rtl/jcs_ctrl.sv
module jcs_ctrl
    import jcs_pkg::*;
#(
    parameter int unsigned IR_W        = 6,
    parameter int unsigned PKT_W       = 16,
    parameter int unsigned ROM_DEPTH   = 16,
    parameter int unsigned IDLE_TCK    = 24,
    parameter int unsigned DUMMY_WORDS = 2,
    parameter logic [15:0] DUMMY_WORD  = 16'h2000,
    parameter logic [IR_W-1:0] OPC_CFGIN  = 6'h05,
    parameter logic [IR_W-1:0] OPC_SHUTDN = 6'h0D,
    localparam int unsigned CNT_W = $clog2(ROM_DEPTH + 1),
    localparam int unsigned AW    = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] pkt_cnt,
    input  logic             tck,
    input  logic             fall_p,
    output logic [AW-1:0]    rom_addr,
    input  logic [PKT_W-1:0] rom_data,
    output logic             tms,
    output logic             tdi,
    output logic             busy,
    output logic             done
);
    localparam int unsigned MAXA   = (IDLE_TCK > IR_W) ? IDLE_TCK : IR_W;
    localparam int unsigned MAXLEN = (MAXA > 8) ? MAXA : 8;
    localparam int unsigned IDX_W  = $clog2(MAXLEN + 1);
    localparam int unsigned WSEL_W = $clog2(ROM_DEPTH + DUMMY_WORDS + 1);
    localparam int unsigned BSEL_W = (PKT_W > 1) ? $clog2(PKT_W) : 1;
    localparam int unsigned IRI_W  = (IR_W > 1) ? $clog2(IR_W) : 1;

    phase_t            ph;
    logic [IDX_W-1:0]  idx;
    logic [WSEL_W-1:0] wsel;
    logic [BSEL_W-1:0] bsel;
    logic [WSEL_W-1:0] n_q;

    int unsigned       seg_len;
    logic              seg_last;
    logic              dr_last;
    logic [WSEL_W-1:0] last_word;
    logic [WSEL_W-1:0] n_in;
    logic [PKT_W-1:0]  cur_word;
    logic [IRI_W-1:0]  ir_bit;
    pin_t              pin;

    assign busy      = (ph != PH_IDLE);
    assign last_word = n_q + WSEL_W'(DUMMY_WORDS) - WSEL_W'(1);
    assign n_in      = (pkt_cnt > CNT_W'(ROM_DEPTH)) ? WSEL_W'(ROM_DEPTH) : WSEL_W'(pkt_cnt);
    assign ir_bit    = idx[IRI_W-1:0];
    assign rom_addr  = (wsel < WSEL_W'(ROM_DEPTH)) ? AW'(wsel) : '0;
    assign cur_word  = (wsel < n_q) ? rom_data : PKT_W'(DUMMY_WORD);
    assign dr_last   = (wsel == last_word) && (bsel == BSEL_W'(PKT_W - 1));

    always_comb begin
        case (ph)
            PH_IR1, PH_IR2: seg_len = IR_W;
            PH_WAIT:        seg_len = IDLE_TCK;
            default:        seg_len = walk_len(ph);
        endcase
        if (ph == PH_DR) seg_last = dr_last;
        else             seg_last = (idx == IDX_W'(seg_len - 1));
    end

    always_comb begin
        pin.tms = 1'b1;
        pin.tdi = 1'b0;
        case (ph)
            PH_IDLE: ;
            PH_IR1: begin
                pin.tms = seg_last;
                pin.tdi = OPC_CFGIN[ir_bit];
            end
            PH_IR2: begin
                pin.tms = seg_last;
                pin.tdi = OPC_SHUTDN[ir_bit];
            end
            PH_DR: begin
                pin.tms = seg_last;
                pin.tdi = cur_word[BSEL_W'(PKT_W - 1) - bsel];
            end
            default: pin.tms = walk_tms(ph, 32'(idx));
        endcase
    end

    assign tms = pin.tms;
    assign tdi = pin.tdi;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            idx  <= '0;
            wsel <= '0;
            bsel <= '0;
            n_q  <= '0;
            done <= 1'b0;
        end else if (ph == PH_IDLE) begin
            if (start) begin
                ph   <= PH_TLR_IN;
                idx  <= '0;
                wsel <= '0;
                bsel <= '0;
                n_q  <= n_in;
                done <= 1'b0;
            end
        end else if (fall_p) begin
            if (seg_last) begin
                ph   <= next_phase(ph);
                idx  <= '0;
                wsel <= '0;
                bsel <= '0;
                if (ph == PH_TLR_OUT) done <= 1'b1;
            end else begin
                idx <= idx + IDX_W'(1);
                if (ph == PH_DR) begin
                    if (bsel == BSEL_W'(PKT_W - 1)) begin
                        bsel <= '0;
                        wsel <= wsel + WSEL_W'(1);
                    end else begin
                        bsel <= bsel + BSEL_W'(1);
                    end
                end
            end
        end
    end

    // R1
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !fall_p) |=> busy);

    // R2
    entry_tms_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (tms && ph == PH_TLR_IN));

    // R7
    pins_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi)));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !fall_p) |=> ($stable(ph) && $stable(idx)));

    // R10
    done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

endmodule

// File: rtl/jcs_seq.sv
module jcs_seq #(
    parameter int unsigned TCK_HALF    = 2,
    parameter int unsigned IR_W        = 6,
    parameter int unsigned PKT_W       = 16,
    parameter int unsigned ROM_DEPTH   = 16,
    parameter int unsigned IDLE_TCK    = 24,
    parameter int unsigned DUMMY_WORDS = 2,
    parameter logic [15:0] DUMMY_WORD  = 16'h2000,
    parameter logic [IR_W-1:0] OPC_CFGIN  = 6'h05,
    parameter logic [IR_W-1:0] OPC_SHUTDN = 6'h0D,
    localparam int unsigned CNT_W = $clog2(ROM_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] pkt_cnt,
    output logic             tck,
    output logic             tms,
    output logic             tdi,
    output logic             busy,
    output logic             done
);
    localparam int unsigned AW = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;

    logic             fall_p;
    logic [AW-1:0]    rom_addr;
    logic [PKT_W-1:0] rom_data;

    jcs_tck_gen #(.TCK_HALF(TCK_HALF)) tck_i (
        .clk    (clk),
        .rst    (rst),
        .en     (busy),
        .tck    (tck),
        .fall_p (fall_p)
    );

    jcs_pkt_rom #(.DEPTH(ROM_DEPTH), .PKT_W(PKT_W)) rom_i (
        .addr (rom_addr),
        .data (rom_data)
    );

    jcs_ctrl #(
        .IR_W        (IR_W),
        .PKT_W       (PKT_W),
        .ROM_DEPTH   (ROM_DEPTH),
        .IDLE_TCK    (IDLE_TCK),
        .DUMMY_WORDS (DUMMY_WORDS),
        .DUMMY_WORD  (DUMMY_WORD),
        .OPC_CFGIN   (OPC_CFGIN),
        .OPC_SHUTDN  (OPC_SHUTDN)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .pkt_cnt  (pkt_cnt),
        .tck      (tck),
        .fall_p   (fall_p),
        .rom_addr (rom_addr),
        .rom_data (rom_data),
        .tms      (tms),
        .tdi      (tdi),
        .busy     (busy),
        .done     (done)
    );

endmodule

// File: tb/jcs_seq_tb_top.sv
`timescale 1ns/1ps
module jcs_seq_tb_top;
    localparam int HALF   = 2;
    localparam int PER_NS = 2 * HALF * 20;
    localparam int IDLE   = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [4:0] pkt_cnt = '0;
    logic       tck, tms, tdi, busy, done;

    int vectors = 0;
    int errors  = 0;
    longint unsigned cyc = 0;

    always #10 clk = ~clk;

    jcs_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .pkt_cnt(pkt_cnt),
        .tck(tck), .tms(tms), .tdi(tdi), .busy(busy), .done(done)
    );

    typedef enum logic [3:0] {
        T_TLR, T_RTI, T_SDR, T_CDR, T_SHDR, T_E1DR, T_PDR, T_E2DR, T_UDR,
        T_SIR, T_CIR, T_SHIR, T_E1IR, T_PIR, T_E2IR, T_UIR
    } tap_t;

    function automatic tap_t tap_nx(tap_t s, logic m);
        case (s)
            T_TLR:  return m ? T_TLR  : T_RTI;
            T_RTI:  return m ? T_SDR  : T_RTI;
            T_SDR:  return m ? T_SIR  : T_CDR;
            T_CDR:  return m ? T_E1DR : T_SHDR;
            T_SHDR: return m ? T_E1DR : T_SHDR;
            T_E1DR: return m ? T_UDR  : T_PDR;
            T_PDR:  return m ? T_E2DR : T_PDR;
            T_E2DR: return m ? T_UDR  : T_SHDR;
            T_UDR:  return m ? T_SDR  : T_RTI;
            T_SIR:  return m ? T_TLR  : T_CIR;
            T_CIR:  return m ? T_E1IR : T_SHIR;
            T_SHIR: return m ? T_E1IR : T_SHIR;
            T_E1IR: return m ? T_UIR  : T_PIR;
            T_PIR:  return m ? T_E2IR : T_PIR;
            T_E2IR: return m ? T_UIR  : T_SHIR;
            default: return m ? T_SDR : T_RTI;
        endcase
    endfunction

    function automatic logic [15:0] exp_word(int i, int n);
        if (i >= n) return 16'h2000;
        case (i)
            0: return 16'hFFFF;
            1: return 16'hAA99;
            2: return 16'h5566;
            3: return 16'h30A1;
            4: return 16'h0007;
            default: return 16'h2000;
        endcase
    endfunction

    function automatic int exp_rises(int n);
        return 61 + 16 * (n + 2);
    endfunction

    // Behavioural target TAP and logs
    tap_t        st;
    logic [5:0]  ir_sr;
    logic [5:0]  ir_log [4];
    int          ir_n, rise_cnt, dr_bits, wn, idle_cnt, per_bad, pin_bad;
    logic [15:0] acc;
    logic [15:0] words [32];
    logic        tms_hist [512];
    longint      last_t;
    logic        p_tck, p_tms, p_tdi;

    always @(posedge tck) begin
        tap_t nx;
        if (rise_cnt < 512) tms_hist[rise_cnt] = tms;
        rise_cnt++;
        if (last_t != 0 && ($time - last_t) != PER_NS) per_bad++;
        last_t = $time;
        if (st == T_SHIR) ir_sr = {tdi, ir_sr[5:1]};
        if (st == T_SHDR) begin
            acc = {acc[14:0], tdi};
            if ((dr_bits % 16) == 15 && wn < 32) begin
                words[wn] = acc;
                wn++;
            end
            dr_bits++;
        end
        if (ir_n == 2 && !tms && (st == T_UIR || st == T_RTI)) idle_cnt++;
        nx = tap_nx(st, tms);
        if (nx == T_UIR && ir_n < 4) begin
            ir_log[ir_n] = ir_sr;
            ir_n++;
        end
        st = nx;
    end

    // R7 observer: pins must not move while TCK stays high
    always @(negedge clk) begin
        if (tck && p_tck && (tms !== p_tms || tdi !== p_tdi)) pin_bad++;
        p_tck = tck;
        p_tms = tms;
        p_tdi = tdi;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        st = T_TLR; ir_sr = '0; ir_n = 0; rise_cnt = 0; dr_bits = 0; wn = 0;
        idle_cnt = 0; per_bad = 0; pin_bad = 0; acc = '0; last_t = 0;
    endtask

    task automatic run_one(input int cnt, input bit inject, input int delay);
        int n;
        int guard;
        int bad_w;
        int first_bad;
        bit ones5;
        n = (cnt > 16) ? 16 : cnt;
        clear_log();
        pkt_cnt = 5'(cnt);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        // R1: busy the cycle after start
        check(busy === 1'b1 && done === 1'b0, "R1 busy after start", {busy, done}, 2'b10);
        if (inject) begin
            repeat (delay) @(negedge clk);
            if (busy) begin
                start = 1'b1;
                @(negedge clk) start = 1'b0;
            end
        end
        guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        // R10
        check(done === 1'b1 && busy === 1'b0, "R10 end flags", {done, busy}, 2'b10);
        // R8: tck low once idle and period held
        check(tck === 1'b0 && per_bad == 0, "R8 tck period/idle", per_bad, 0);
        // R7
        check(pin_bad == 0, "R7 pins stable while tck high", pin_bad, 0);
        // R2
        ones5 = 1'b1;
        for (int i = 0; i < 5; i++) if (tms_hist[i] !== 1'b1) ones5 = 1'b0;
        check(ones5 && tms_hist[5] === 1'b0, "R2 opening walk", {ones5, tms_hist[5]}, 2'b10);
        // R3
        check(ir_n == 2, "R3 instruction count", ir_n, 2);
        check(ir_log[0] == 6'h05, "R3 first instruction", ir_log[0], 6'h05);
        check(ir_log[1] == 6'h0D, "R3 shutdown instruction", ir_log[1], 6'h0D);
        // R5: clamp and word count
        check(wn == n + 2 && dr_bits == 16 * (n + 2), "R5 word count", wn, n + 2);
        // R4: contents and order
        bad_w = 0;
        first_bad = -1;
        for (int i = 0; i < n + 2 && i < 32; i++) begin
            if (words[i] !== exp_word(i, n)) begin
                bad_w++;
                if (first_bad < 0) first_bad = i;
            end
        end
        if (first_bad >= 0)
            check(1'b0, "R4 packet word", words[first_bad], exp_word(first_bad, n));
        else
            check(1'b1, "R4 packet words", 0, 0);
        // R6
        check(idle_cnt == IDLE, "R6 idle length", idle_cnt, IDLE);
        check(st == T_TLR, "R6 final TAP state", st, T_TLR);
        // R6/R9: total length unchanged by stray starts
        check(rise_cnt == exp_rises(n), inject ? "R9 length with stray start" : "R6 total tck",
              rise_cnt, exp_rises(n));
    endtask

    initial begin
        int seed;
        int unsigned r;
        seed = 32'h5EED;
        r = $urandom(seed);
        clear_log();
        p_tck = 1'b0; p_tms = 1'b1; p_tdi = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11
        check(busy === 1'b0 && done === 1'b0 && tck === 1'b0 && tms === 1'b1,
              "R11 reset state", {busy, done, tck, tms}, 4'b0001);

        // directed corners
        run_one(7, 1'b0, 0);
        run_one(0, 1'b0, 0);
        run_one(16, 1'b0, 0);
        run_one(17, 1'b0, 0);
        run_one(31, 1'b1, 5);
        run_one(1, 1'b1, 300);

        // R10: done held while idle
        repeat (20) @(negedge clk);
        check(done === 1'b1 && tck === 1'b0, "R10 done held idle", {done, tck}, 2'b10);

        // random mix
        for (int k = 0; k < 10; k++) begin
            run_one(int'($urandom_range(0, 20)), 1'($urandom_range(0, 1)),
                    int'($urandom_range(10, 900)));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule